// File: doc/BRIEF.md
# Polled Console Peripheral

This block gives a processor a simple character console that it drives with ordinary word loads and stores. It decodes four word registers within a 32-bit address space: an input pair (status and data) fed by a byte-wide receive port, and an output pair (status and data) that drives a byte-wide transmit port with a valid/accept handshake.

Software polls bit 0 of a status register until it reads 1, which always means the processor may act now. For input, this means a byte is waiting. For output, it means the transmitter can take a new byte. The ready flags are set from the device side. They are cleared as a side effect of the processor loading input data or storing output data.

A receive byte that arrives while the previous one is still unread is dropped, and the drop is recorded in a sticky flag.

Top module: `mmio_console`

## Requirements
- R1: After reset, the input status register reads 0, the output status register reads 1 and `tx_valid` is 0.
- R2: Registers sit at BASE+0x0 (input status), BASE+0x4 (input data), BASE+0x8 (output status) and BASE+0xC (output data), with BASE = 0x7FFFF000. `bus_rdata` is combinational and is 0 in three cases: when `bus_rd` is low, for any other address, and for a load of output data.
- R3: A byte taken on `rx_valid` sets input status bit 0 on the next cycle, and the byte becomes readable at input data.
- R4: A load of input data returns the byte in bits 7:0 with bits 31:8 zero, and clears input status bit 0 from the next cycle. If a receive byte arrives in the same cycle as that load, the new byte is kept and bit 0 stays 1.
- R5: A receive byte that arrives while input status bit 0 is 1, and input data is not being loaded, is dropped and sets input status bit 1. Bit 1 holds until a load of input status. That load returns bit 1 as set and then clears it, unless a new drop occurs in the same cycle, in which case the bit stays set.
- R6: A store to output data while output status bit 0 is 1 latches `bus_wdata[7:0]`. From the next cycle, `tx_valid` is 1, `tx_byte` holds that byte and output status bit 0 reads 0.
- R7: `tx_byte` and `tx_valid` hold until a cycle with `tx_valid` and `tx_accept` both high. From the following cycle, `tx_valid` is 0 and output status bit 0 reads 1.
- R8: A store to output data while `tx_valid` is 1 is ignored, including in the cycle the pending byte is accepted.
- R9: Stores to the status registers and to addresses outside the window change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Load strobe |
| bus_wr | input | 1 | Store strobe |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, combinational |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_byte | input | 8 | Receive byte |
| tx_valid | output | 1 | Transmit byte pending |
| tx_byte | output | 8 | Transmit byte |
| tx_accept | input | 1 | Device takes the pending byte |

## Verification
The hardest cases to reach are the same-cycle collisions:
- a receive byte landing in the cycle the processor loads input data;
- a dropped byte landing in the cycle the processor loads input status;
- a store to output data in the very cycle the device accepts the previous byte.

Directed cycles place each of these collisions deliberately. A stretch of random traffic then mixes strobes, addresses and handshakes. Throughout, a behavioural model predicts the read data and transmit outputs, and the bench compares them every clock.

// File: rtl/mmio_console.sv
module mmio_console #(
  parameter logic [31:0] BASE = 32'h7FFF_F000,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic [BW-1:0] rx_byte,
  output logic          tx_valid,
  output logic [BW-1:0] tx_byte,
  input  logic          tx_accept
);
  localparam logic [AW-1:0] A_ISTAT = BASE;
  localparam logic [AW-1:0] A_IDATA = BASE + 4;
  localparam logic [AW-1:0] A_OSTAT = BASE + 8;
  localparam logic [AW-1:0] A_ODATA = BASE + 12;

  logic          in_rdy, ovr;
  logic [BW-1:0] in_byte;

  wire rd_istat = bus_rd && bus_addr == A_ISTAT;
  wire rd_idata = bus_rd && bus_addr == A_IDATA;
  wire wr_odata = bus_wr && bus_addr == A_ODATA;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_rdy   <= 1'b0;
      in_byte  <= '0;
      ovr      <= 1'b0;
      tx_valid <= 1'b0;
      tx_byte  <= '0;
    end else begin
      if (rx_valid && (!in_rdy || rd_idata)) begin
        in_rdy  <= 1'b1;
        in_byte <= rx_byte;
      end else if (rd_idata) begin
        in_rdy <= 1'b0;
      end

      if (rx_valid && in_rdy && !rd_idata) ovr <= 1'b1;
      else if (rd_istat)                   ovr <= 1'b0;

      if (tx_valid && tx_accept) begin
        tx_valid <= 1'b0;
      end else if (wr_odata && !tx_valid) begin
        tx_valid <= 1'b1;
        tx_byte  <= bus_wdata[BW-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        A_ISTAT: bus_rdata = DW'({ovr, in_rdy});
        A_IDATA: bus_rdata = DW'(in_byte);
        A_OSTAT: bus_rdata = DW'(!tx_valid);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

module mmio_console_chk #(
  parameter logic [31:0] BASE = 32'h7FFF_F000,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          rx_valid,
  input logic          tx_valid,
  input logic [BW-1:0] tx_byte,
  input logic          tx_accept,
  input logic          in_rdy,
  input logic          ovr
);
  wire in_win = bus_addr == BASE || bus_addr == BASE + 4 ||
                bus_addr == BASE + 8 || bus_addr == BASE + 12;

  // R2
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == '0);

  // R2
  window_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !in_win |-> bus_rdata == '0);

  // R4
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == BASE + 4 && !rx_valid |=> !in_rdy);

  // R5
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !(bus_rd && bus_addr == BASE) |=> ovr);

  // R6
  store_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == BASE + 12 && !tx_valid |=>
      tx_valid && tx_byte == $past(bus_wdata[BW-1:0]));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_accept |=> tx_valid && $stable(tx_byte));

  // R8
  busy_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_accept |=> !tx_valid);
endmodule

bind mmio_console mmio_console_chk #(.BASE(BASE), .AW(AW), .DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_accept(tx_accept),
  .in_rdy(in_rdy), .ovr(ovr)
);

// File: tb/test_mmio_console.sv
module test_mmio_console;
  localparam logic [31:0] B = 32'h7FFF_F000;

  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_rd = 0, bus_wr = 0, rx_valid = 0, tx_accept = 0;
  logic [7:0] rx_byte = 0;
  logic [31:0] bus_rdata;
  logic tx_valid;
  logic [7:0] tx_byte;

  mmio_console i_mmio_console (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  bit m_full = 0, m_ovr = 0, m_busy = 0;
  byte unsigned m_byte = 0, m_obyte = 0;
  byte unsigned sent[$];

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic rd, logic [31:0] a);
    if (!rd) return 0;
    if (a == B) return {30'd0, m_ovr, m_full};
    if (a == B + 4) return {24'd0, m_byte};
    if (a == B + 8) return {31'd0, !m_busy};
    return 0;
  endfunction

  task automatic cyc(string tag, logic rd, logic wr, logic [31:0] a, logic [31:0] wd,
                     logic rxv, logic [7:0] rxb, logic acc);
    bit ri, rs, busy0;
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    rx_valid = rxv; rx_byte = rxb; tx_accept = acc;
    #1;
    chk(tag, "rdata", bus_rdata, exp_rd(rd, a));
    chk(tag, "tx_valid", {31'd0, tx_valid}, {31'd0, m_busy});
    if (m_busy) chk(tag, "tx_byte", {24'd0, tx_byte}, {24'd0, m_obyte});
    @(posedge clk);
    ri = rd && a == B + 4;
    rs = rd && a == B;
    busy0 = m_busy;
    if (rxv && m_full && !ri) m_ovr = 1;
    else if (rs) m_ovr = 0;
    if (rxv && (!m_full || ri)) begin m_full = 1; m_byte = rxb; end
    else if (ri) m_full = 0;
    if (busy0 && acc) begin
      m_busy = 0;
      if (sent.size() > 0) chk(tag, "accepted byte", {24'd0, tx_byte}, {24'd0, sent.pop_front()});
    end else if (wr && a == B + 12 && !busy0) begin
      m_busy = 1; m_obyte = wd[7:0]; sent.push_back(wd[7:0]);
    end
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #6;
    // R1 reset values visible while reset is held
    chk("R1", "tx_valid in reset", {31'd0, tx_valid}, 0);
    @(negedge clk); rst_n = 1;
    cyc("R1", 1, 0, B, 0, 0, 0, 0);
    cyc("R1", 1, 0, B + 8, 0, 0, 0, 0);
    // R2 map, idle and out-of-window reads
    cyc("R2", 0, 0, B + 8, 0, 0, 0, 0);
    cyc("R2", 1, 0, B + 12, 0, 0, 0, 0);
    cyc("R2", 1, 0, B + 16, 0, 0, 0, 0);
    cyc("R2", 1, 0, B + 2, 0, 0, 0, 0);
    cyc("R2", 1, 0, 32'h7FFF_E008, 0, 0, 0, 0);
    // R3 receive sets ready
    cyc("R3", 0, 0, 0, 0, 1, 8'hA5, 0);
    cyc("R3", 1, 0, B, 0, 0, 0, 0);
    // R4 load returns byte and clears
    cyc("R4", 1, 0, B + 4, 0, 0, 0, 0);
    cyc("R4", 1, 0, B, 0, 0, 0, 0);
    // R4 arrival during load keeps new byte
    cyc("R4", 0, 0, 0, 0, 1, 8'h11, 0);
    cyc("R4", 1, 0, B + 4, 0, 1, 8'h22, 0);
    cyc("R4", 1, 0, B, 0, 0, 0, 0);
    cyc("R4", 1, 0, B + 4, 0, 0, 0, 0);
    // R5 overrun drop and sticky flag
    cyc("R5", 0, 0, 0, 0, 1, 8'h31, 0);
    cyc("R5", 0, 0, 0, 0, 1, 8'h32, 0);
    cyc("R5", 1, 0, B + 4, 0, 0, 0, 0);
    cyc("R5", 1, 0, B, 0, 0, 0, 0);
    cyc("R5", 1, 0, B, 0, 0, 0, 0);
    // R5 drop in same cycle as status load: set wins
    cyc("R5", 0, 0, 0, 0, 1, 8'h41, 0);
    cyc("R5", 1, 0, B, 0, 1, 8'h42, 0);
    cyc("R5", 1, 0, B, 0, 0, 0, 0);
    cyc("R5", 1, 0, B, 0, 0, 0, 0);
    cyc("R5", 1, 0, B + 4, 0, 0, 0, 0);
    // R9 stores to status and outside window ignored
    cyc("R9", 0, 1, B, 32'hFFFF_FFFF, 0, 0, 0);
    cyc("R9", 0, 1, B + 8, 32'h0, 0, 0, 0);
    cyc("R9", 0, 1, B + 4, 32'h77, 0, 0, 0);
    cyc("R9", 0, 1, B + 16, 32'h78, 0, 0, 0);
    cyc("R9", 1, 0, B, 0, 0, 0, 0);
    cyc("R9", 1, 0, B + 8, 0, 0, 0, 0);
    // R6 store starts a transmit
    cyc("R6", 0, 1, B + 12, 32'hDEAD_BE5C, 0, 0, 0);
    cyc("R6", 1, 0, B + 8, 0, 0, 0, 0);
    // R8 store while busy ignored
    cyc("R8", 0, 1, B + 12, 32'h99, 0, 0, 0);
    // R7 hold then accept
    idle("R7", 3);
    cyc("R8", 0, 1, B + 12, 32'h98, 0, 0, 1);
    cyc("R7", 1, 0, B + 8, 0, 0, 0, 0);
    cyc("R6", 0, 1, B + 12, 32'h6B, 0, 0, 0);
    cyc("R7", 0, 0, 0, 0, 0, 0, 1);
    cyc("R7", 1, 0, B + 8, 0, 0, 0, 0);
    // mixed random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a = B + 32'($urandom_range(0, 5) * 4);
      cyc("R2", $urandom_range(0, 1) == 1, $urandom_range(0, 2) == 0, a, $urandom,
          $urandom_range(0, 3) == 0, 8'($urandom), $urandom_range(0, 2) == 0);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule